// File: doc/BRIEF.md
# LED and Stop Pin Controller

This block drives the indicator and stop pins of a voice playback device. It holds three configuration registers: two mode registers and a five-bit stop register. An external program loader writes them through a simple write port. From these registers, a playback-active flag and a per-section LED flag, the block forms the levels of two LED pins and five stop pins. Two of those pins are shared between functions.

The LEDs can be lit steadily, or they can blink. A divider on a fixed-rate tick input makes the blink. The two LEDs blink either in step or in opposite phase. Each LED can be gated by the section flag. One shared pin carries either the second LED or stop output C. The other shared pin carries either stop output A or a BUSY level that follows playback.

Top module: `led_stop_ctrl`

## Requirements
- R1: Mode register 0 bit 7 at 1 makes the LEDs blink and at 0 makes them steady. A blinking LED is lit for TICKS_PER_HALF ticks and then dark for TICKS_PER_HALF ticks, so the duty cycle is 50 %. The lit half comes first after reset.
- R2: Mode register 0 bit 6 at 1 routes the second LED to the shared LED2/STPC pin. At 0 the pin carries stop bit 2 (stop C).
- R3: Mode register 0 bit 2 at 1 routes stop bit 0 (stop A) to the STPA/BUSY pin. At 0 the pin carries BUSY, which is high while `playing` is high.
- R4: Mode register 1 bit 5 at 1 makes the two blinking LEDs opposite in phase. At 0 they blink in step.
- R5: Mode register 1 bit 4 at 1 lights LED1 only while `sect_led` is high. At 0 LED1 is not gated by `sect_led`.
- R6: Mode register 1 bit 3 at 1 enables LED2 by `playing` and `sect_led` together. At 0 LED2 is enabled by stop bit 2.
- R7: Stop register bits 0 to 4 drive stop A to E, and a bit at 1 drives its pin high. Written data bits 7 to 5 of the stop register are discarded.
- R8: Reset sets both mode registers to 8'hFF, sets the stop register to 5'h1F and starts the blink phase at lit.
- R9: An LED whose enable is false drives 0. LED1 is enabled only while `playing` is high.
- R10: A write with `wr_addr` 0, 1 or 2 loads mode register 0, mode register 1 or the stop register, and the pins reflect it one cycle later. A write with address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode 0, 1 mode 1, 2 stop |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Fixed-rate blink time base, one-cycle pulses |
| playing | input | 1 | Playback active flag |
| sect_led | input | 1 | Per-section LED-on flag |
| led1_o | output | 1 | LED1 pin |
| led2_stpc_o | output | 1 | LED2 or stop C pin |
| stpa_busy_o | output | 1 | Stop A or BUSY pin |
| stpb_o | output | 1 | Stop B pin |
| stpd_o | output | 1 | Stop D pin |
| stpe_o | output | 1 | Stop E pin |

## Verification
The bench builds the block with TICKS_PER_HALF set to 3. With that value a full blink period is six tick pulses. The bench can therefore step through several lit and dark halves and count the half-period boundaries exactly. It can also compare in-step and opposite-phase blinking within a few dozen cycles. The pin mapping is covered by steady-mode vectors, where the blink phase does not matter.

// File: rtl/led_stop_pkg.sv
package led_stop_pkg;

  localparam int NUM_STOP = 5;

  localparam logic [1:0] ADDR_MODE0 = 2'd0;
  localparam logic [1:0] ADDR_MODE1 = 2'd1;
  localparam logic [1:0] ADDR_STOP  = 2'd2;

  // mode register 0 fields
  localparam int M0_BLINK   = 7;
  localparam int M0_L2_PIN  = 6;
  localparam int M0_SA_PIN  = 2;
  // mode register 1 fields
  localparam int M1_ALT     = 5;
  localparam int M1_L1_SECT = 4;
  localparam int M1_L2_SECT = 3;

  localparam int ST_A = 0;
  localparam int ST_B = 1;
  localparam int ST_C = 2;
  localparam int ST_D = 3;
  localparam int ST_E = 4;

  typedef struct packed {
    logic [7:0]          mode0;
    logic [7:0]          mode1;
    logic [NUM_STOP-1:0] stop;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode0: 8'hFF, mode1: 8'hFF, stop: '1};

endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_stop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output cfg_t       cfg_q
);

  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_MODE0: cfg_d.mode0 = wr_data;
        ADDR_MODE1: cfg_d.mode1 = wr_data;
        ADDR_STOP:  cfg_d.stop  = wr_data[NUM_STOP-1:0];
        default:    cfg_d       = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int TICKS_PER_HALF = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase_q
);

  localparam int CW = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_d;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (cnt_q == LAST) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/led_pin_mux.sv
module led_pin_mux
  import led_stop_pkg::*;
(
  input  cfg_t cfg,
  input  logic phase,
  input  logic playing,
  input  logic sect_led,
  output logic led1_o,
  output logic led2_stpc_o,
  output logic stpa_busy_o,
  output logic stpb_o,
  output logic stpd_o,
  output logic stpe_o
);

  logic led1_en, led2_en;
  logic wave1, wave2;
  logic led1_lvl, led2_lvl;

  always_comb begin
    led1_en = playing & (cfg.mode1[M1_L1_SECT] ? sect_led : 1'b1);
    led2_en = cfg.mode1[M1_L2_SECT] ? (playing & sect_led) : cfg.stop[ST_C];

    // phase 0 is the lit half
    wave1 = ~phase;
    wave2 = cfg.mode1[M1_ALT] ? phase : ~phase;

    led1_lvl = led1_en & (cfg.mode0[M0_BLINK] ? wave1 : 1'b1);
    led2_lvl = led2_en & (cfg.mode0[M0_BLINK] ? wave2 : 1'b1);

    led1_o      = led1_lvl;
    led2_stpc_o = cfg.mode0[M0_L2_PIN] ? led2_lvl : cfg.stop[ST_C];
    stpa_busy_o = cfg.mode0[M0_SA_PIN] ? cfg.stop[ST_A] : playing;
    stpb_o      = cfg.stop[ST_B];
    stpd_o      = cfg.stop[ST_D];
    stpe_o      = cfg.stop[ST_E];
  end

endmodule

// File: rtl/led_stop_ctrl.sv
module led_stop_ctrl
  import led_stop_pkg::*;
#(
  parameter int TICKS_PER_HALF = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       tick,
  input  logic       playing,
  input  logic       sect_led,
  output logic       led1_o,
  output logic       led2_stpc_o,
  output logic       stpa_busy_o,
  output logic       stpb_o,
  output logic       stpd_o,
  output logic       stpe_o
);

  cfg_t cfg_q;
  logic blink_phase;

  led_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_q   (cfg_q)
  );

  led_blink_div #(.TICKS_PER_HALF(TICKS_PER_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .phase_q (blink_phase)
  );

  led_pin_mux u_mux (
    .cfg         (cfg_q),
    .phase       (blink_phase),
    .playing     (playing),
    .sect_led    (sect_led),
    .led1_o      (led1_o),
    .led2_stpc_o (led2_stpc_o),
    .stpa_busy_o (stpa_busy_o),
    .stpb_o      (stpb_o),
    .stpd_o      (stpd_o),
    .stpe_o      (stpe_o)
  );

endmodule

// File: rtl/led_stop_chk.sv
module led_stop_chk
  import led_stop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       tick,
  input logic       playing,
  input logic       sect_led,
  input cfg_t       cfg,
  input logic       phase,
  input logic       led1_o,
  input logic       led2_stpc_o,
  input logic       stpa_busy_o,
  input logic       stpb_o,
  input logic       stpd_o,
  input logic       stpe_o
);

  // R9: LED1 stays dark while playback is idle
  p_led1_idle_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !playing |-> !led1_o);

  // R7, R10: a stop register write reaches the pins one cycle later
  p_stop_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_STOP) |=>
      (stpb_o == $past(wr_data[ST_B]) && stpd_o == $past(wr_data[ST_D]) &&
       stpe_o == $past(wr_data[ST_E])));

  // R10: address 3 leaves every register unchanged
  p_bad_addr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> $stable(cfg));

  // R3: in BUSY mode the shared pin follows playback
  p_busy_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.mode0[M0_SA_PIN] |-> (stpa_busy_o == playing));

  // R1: the blink phase moves only on a tick
  p_phase_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  // R4: in-step blinking with both LEDs enabled keeps them equal
  p_sync_blink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode0[M0_BLINK] && cfg.mode0[M0_L2_PIN] && !cfg.mode1[M1_ALT] &&
     !cfg.mode1[M1_L1_SECT] && !cfg.mode1[M1_L2_SECT] && cfg.stop[ST_C] && playing)
      |-> (led1_o == led2_stpc_o));

endmodule

bind led_stop_ctrl led_stop_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .tick        (tick),
  .playing     (playing),
  .sect_led    (sect_led),
  .cfg         (cfg_q),
  .phase       (blink_phase),
  .led1_o      (led1_o),
  .led2_stpc_o (led2_stpc_o),
  .stpa_busy_o (stpa_busy_o),
  .stpb_o      (stpb_o),
  .stpd_o      (stpd_o),
  .stpe_o      (stpe_o)
);

// File: tb/sim_led_stop_ctrl.sv
module sim_led_stop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tick = 1'b0;
  logic playing = 1'b0;
  logic sect_led = 1'b0;
  logic led1_o, led2_stpc_o, stpa_busy_o, stpb_o, stpd_o, stpe_o;

  int n_vec = 0;
  int n_bad = 0;
  int ticks_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_stop_ctrl #(.TICKS_PER_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .playing(playing), .sect_led(sect_led),
    .led1_o(led1_o), .led2_stpc_o(led2_stpc_o), .stpa_busy_o(stpa_busy_o),
    .stpb_o(stpb_o), .stpd_o(stpd_o), .stpe_o(stpe_o)
  );

  // vector: mode0, mode1, stop, playing, sect_led, expected
  // expected order: led1, led2/stpc, stpa/busy, stpb, stpd, stpe (blink off)
  localparam logic [28:0] VEC [8] = '{
    {8'h40, 8'h00, 5'h04, 1'b1, 1'b0, 6'b111000},
    {8'h44, 8'h10, 5'h1B, 1'b1, 1'b0, 6'b001111},
    {8'h00, 8'h18, 5'h04, 1'b0, 1'b1, 6'b010000},
    {8'h40, 8'h08, 5'h00, 1'b1, 1'b1, 6'b111000},
    {8'h40, 8'h08, 5'h00, 1'b1, 1'b0, 6'b101000},
    {8'h44, 8'h18, 5'h10, 1'b1, 1'b1, 6'b110001},
    {8'h04, 8'h00, 5'h02, 1'b0, 1'b0, 6'b000100},
    {8'h40, 8'h00, 5'h08, 1'b0, 1'b1, 6'b000010}
  };

  function automatic logic [5:0] pins();
    return {led1_o, led2_stpc_o, stpa_busy_o, stpb_o, stpd_o, stpe_o};
  endfunction

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    ticks_seen++;
    #1;
  endtask

  function automatic logic lit_exp();
    return ((ticks_seen / HALF) % 2) == 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R8 reset state, idle: stop pins all high, LEDs dark
    chk("R8 reset idle", pins(), 6'b001111);
    playing = 1'b1; sect_led = 1'b1; #1;
    // R8, R1: blink on, lit half first; alternate phase puts LED2 dark
    chk("R8 reset playing", pins(), 6'b101111);
    playing = 1'b0; sect_led = 1'b0;

    // table: R2 R3 R5 R6 R7 R9 in steady mode
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, VEC[i][28:21]);
      wr(2'd1, VEC[i][20:13]);
      wr(2'd2, {3'b000, VEC[i][12:8]});
      @(negedge clk);
      playing = VEC[i][7]; sect_led = VEC[i][6];
      #1;
      chk($sformatf("R2/R3/R5/R6/R7/R9 vector %0d", i), pins(), VEC[i][5:0]);
    end

    // R1 and R4: blinking in step, LED2 enabled by stop C
    wr(2'd0, 8'hC0); wr(2'd1, 8'h00); wr(2'd2, 8'h04);
    playing = 1'b1; sect_led = 1'b0; #1;
    chk("R1 blink start", {led1_o, led2_stpc_o}, {lit_exp(), lit_exp()});
    for (int k = 0; k < 2*HALF + 1; k++) begin
      pulse_tick();
      chk("R1/R4 in step", {led1_o, led2_stpc_o}, {lit_exp(), lit_exp()});
    end
    // R4 opposite phase
    wr(2'd1, 8'h20);
    for (int k = 0; k < 2*HALF; k++) begin
      pulse_tick();
      chk("R4 alternate", {led1_o, led2_stpc_o}, {lit_exp(), ~lit_exp()});
    end
    // R1 duty: lit count over one full period
    begin
      int lit_cnt = 0;
      for (int k = 0; k < 2*HALF; k++) begin
        pulse_tick();
        if (led1_o) lit_cnt++;
      end
      chk("R1 duty", 6'(lit_cnt), 6'(HALF));
    end
    // R1 steady: LED1 stays lit across ticks
    wr(2'd0, 8'h40);
    for (int k = 0; k < HALF + 1; k++) begin
      pulse_tick();
      chk("R1 steady", {5'b0, led1_o}, 6'b000001);
    end

    // R10 address 3 is ignored
    wr(2'd3, 8'h00);
    chk("R10 bad address", pins(), 6'b111000);
    // R7 upper bits discarded, R3 stop A selected
    wr(2'd0, 8'h04);
    wr(2'd2, 8'hE0);
    chk("R7 upper bits", pins(), 6'b100000);
    // R9 LED2 disabled by section flag stays dark while blinking
    wr(2'd0, 8'hC0); wr(2'd1, 8'h08);
    sect_led = 1'b0; #1;
    chk("R9 led2 disabled", {5'b0, led2_stpc_o}, 6'b000000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule